// File: doc/BRIEF.md
# Coprocessor Instruction Push Frontend

This block takes 32-bit coprocessor instruction words from four requesting cores and sorts them into three per-thread instruction queues. Three worker cores each own one thread. One boot core can reach every thread. An instruction word holds an 8-bit opcode in bits 31:24 and a 24-bit parameter field in bits 23:0. The frontend moves whole words and does not look inside them.

A worker can push in two ways. The first is a store into an address window. The second is an inline custom instruction, which carries the word rotated left by two bits and may fuse up to four words into one request. Each thread queue holds 32 words and feeds the macro-expansion stage, which pops one word per cycle. A queue slot becomes free only when that stage pops the word. A worker is stalled while its group does not fit. Boot-core stores skip the queue and join the thread's stream after the expander, through a merge mux. When the boot core and a worker target the same thread in the same cycle, the boot core wins, the worker's word is silently lost, and a sticky flag records the event.

The push windows start at `BASE` and are spaced `STRIDE` apart. Window 0 serves thread 0, window 1 serves thread 1 and window 2 serves thread 2. A worker only ever uses window 0, which the block remaps to the worker's own thread.

Top module: `copro_push_front`

## Requirements
- R1: A worker store to window 0 (address `BASE` up to `BASE+STRIDE-1`) goes into that worker's own thread queue, word unchanged. `wk_ready` is high in the request cycle, and the word is at the queue head after the next clock edge.
- R2: A worker store to window 1 or window 2 never receives `wk_ready` and writes nothing. A worker store outside all three windows is accepted and writes nothing.
- R3: An inline request (`wk_inline`=1) ignores the address and pushes to the worker's own thread. Each lane word is rotated right by 2 bits, so bits 1:0 of the lane become bits 31:30 of the queued word.
- R4: An inline request of `wk_count` words (1 to 4, lane 0 first) is accepted in one cycle only if the queue has at least that many free slots. If it does not fit, it is stalled whole. Once accepted, its words pop in lane order.
- R5: Each queue holds 32 words, and `q_full` is high when it holds 32. A store to a full queue is stalled. A slot freed by a pop can be used from the following cycle.
- R6: `q_pop` removes at most one word per cycle per queue, in first-in first-out order. `q_valid` is low when the queue is empty.
- R7: A boot store to window t puts the word on thread t's merge output in the same cycle, with `mx_from_boot`=1 and `ex_ready`[t]=0. The word does not enter the queue.
- R8: If the boot core and worker t both push to thread t in the same cycle, the worker sees `wk_ready`=1 but its word is lost. `drop_flag`[t] then goes high and stays high until reset.
- R9: With no boot store to thread t, the merge output forwards `ex_valid`/`ex_word`, and `ex_ready`[t]=1.
- R10: After reset every queue is empty, and `q_full`, `drop_flag` and `mx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wk_valid | input | NTHR | Worker push request, one bit per worker |
| wk_inline | input | NTHR | 1 = inline (rotated, fusable) request, 0 = store |
| wk_count | input | NTHR*CW | Number of inline words, 1 to LANES |
| wk_addr | input | NTHR*32 | Store address per worker |
| wk_data | input | NTHR*LANES*W | Lane words per worker, lane 0 in the low bits |
| wk_ready | output | NTHR | Request accepted this cycle |
| bt_valid | input | 1 | Boot-core store request |
| bt_addr | input | 32 | Boot store address |
| bt_data | input | W | Boot store word |
| q_valid | output | NTHR | Queue head holds a word |
| q_word | output | NTHR*W | Queue head word |
| q_pop | input | NTHR | Expander takes the head word |
| q_full | output | NTHR | Queue holds DEPTH words |
| ex_valid | input | NTHR | Expander output word valid |
| ex_word | input | NTHR*W | Expander output word |
| ex_ready | output | NTHR | Merge mux accepts the expander word |
| mx_valid | output | NTHR | Merged stream word valid |
| mx_word | output | NTHR*W | Merged stream word |
| mx_from_boot | output | NTHR | Merged word came from the boot core |
| drop_flag | output | NTHR | Sticky: a worker word was lost to a boot store |

## Verification
Two functions can fall in the same cycle: a boot store to a thread and that thread's worker push. The bench provokes this by driving a boot store to window 0 and a worker-0 store in one cycle. It judges the result by four observations: the worker still sees ready, queue 0 stays empty, the boot word is on the merge output, and the drop flag stays set through later idle cycles. A second overlap occurs when a full queue is popped while a stalled store is still waiting. The bench checks that the stall holds in the pop cycle and clears in the following cycle.

// File: rtl/copro_push_pkg.sv
package copro_push_pkg;

  // Undo the inline carrier's rotate-left-by-two.
  function automatic logic [31:0] rot_right2(input logic [31:0] x);
    return {x[1:0], x[31:2]};
  endfunction

  // True when the address lies inside one of nwin push windows.
  function automatic logic in_windows(input logic [31:0] a, input logic [31:0] base,
                                      input logic [31:0] stride, input int unsigned nwin);
    return (a >= base) && ((a - base) < (stride * 32'(nwin)));
  endfunction

  // Window number of an address already known to be inside the windows.
  function automatic logic [31:0] window_of(input logic [31:0] a, input logic [31:0] base,
                                            input logic [31:0] stride);
    return (a - base) / stride;
  endfunction

  // Clamp a fused word count to the lane count.
  function automatic int unsigned clamp_count(input int unsigned c, input int unsigned lanes);
    return (c > lanes) ? lanes : c;
  endfunction

endpackage

// File: rtl/copro_push_route.sv
module copro_push_route
  import copro_push_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned NTHR   = 3,
  parameter logic [31:0] BASE   = 32'hFFE4_0000,
  parameter logic [31:0] STRIDE = 32'h0001_0000,
  localparam int unsigned CW    = $clog2(LANES + 1)
) (
  input  logic               req_valid,
  input  logic               req_inline,
  input  logic [CW-1:0]      req_count,
  input  logic [31:0]        req_addr,
  input  logic [LANES*W-1:0] req_data,
  output logic [CW-1:0]      push_n,
  output logic [LANES*W-1:0] push_words,
  output logic               hang
);

  logic        addr_in;
  logic [31:0] addr_win;

  assign addr_in  = in_windows(req_addr, BASE, STRIDE, NTHR);
  assign addr_win = window_of(req_addr, BASE, STRIDE);

  always_comb begin
    push_n     = '0;
    push_words = '0;
    hang       = 1'b0;
    if (req_valid) begin
      if (req_inline) begin
        push_n = CW'(clamp_count(int'(req_count), LANES));
        for (int k = 0; k < int'(LANES); k++)
          push_words[k*W +: W] = rot_right2(req_data[k*W +: W]);
      end else if (addr_in) begin
        if (addr_win == 32'd0) begin
          push_n            = CW'(1);
          push_words[W-1:0] = req_data[W-1:0];
        end else begin
          hang = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/copro_push_queue.sv
module copro_push_queue #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LANES = 4,
  localparam int unsigned CW   = $clog2(LANES + 1),
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned NW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      wr_n,
  input  logic [LANES*W-1:0] wr_words,
  input  logic               pop_req,
  output logic               valid,
  output logic [W-1:0]       head,
  output logic [NW-1:0]      free,
  output logic               full
);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [NW-1:0] fill;
  logic          pop;

  assign valid = (fill != '0);
  assign full  = (fill == NW'(DEPTH));
  assign free  = NW'(DEPTH) - fill;
  assign head  = store[rptr];
  assign pop   = pop_req && valid;

  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(LANES); k++)
      if (k < int'(wr_n)) store[wptr + AW'(k)] <= wr_words[k*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      wptr <= wptr + AW'(wr_n);
      rptr <= rptr + AW'(pop);
      fill <= fill + NW'(wr_n) - NW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    NW'(wr_n) <= free); // R5

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && valid && wr_n == '0) |=> (free == $past(free) + NW'(1))); // R6

endmodule

// File: rtl/copro_push_merge.sv
module copro_push_merge #(
  parameter int unsigned W = 32
) (
  input  logic         boot_hit,
  input  logic [W-1:0] boot_word,
  input  logic         ex_valid,
  input  logic [W-1:0] ex_word,
  output logic         ex_ready,
  output logic         mx_valid,
  output logic [W-1:0] mx_word,
  output logic         mx_boot
);

  always_comb begin
    ex_ready = !boot_hit;
    mx_boot  = boot_hit;
    mx_valid = boot_hit || ex_valid;
    mx_word  = boot_hit ? boot_word : ex_word;
  end

endmodule

// File: rtl/copro_push_front.sv
module copro_push_front
  import copro_push_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned NTHR   = 3,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned LANES  = 4,
  parameter logic [31:0] BASE   = 32'hFFE4_0000,
  parameter logic [31:0] STRIDE = 32'h0001_0000,
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned NW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTHR-1:0]         wk_valid,
  input  logic [NTHR-1:0]         wk_inline,
  input  logic [NTHR*CW-1:0]      wk_count,
  input  logic [NTHR*32-1:0]      wk_addr,
  input  logic [NTHR*LANES*W-1:0] wk_data,
  output logic [NTHR-1:0]         wk_ready,
  input  logic                    bt_valid,
  input  logic [31:0]             bt_addr,
  input  logic [W-1:0]            bt_data,
  output logic [NTHR-1:0]         q_valid,
  output logic [NTHR*W-1:0]       q_word,
  input  logic [NTHR-1:0]         q_pop,
  output logic [NTHR-1:0]         q_full,
  input  logic [NTHR-1:0]         ex_valid,
  input  logic [NTHR*W-1:0]       ex_word,
  output logic [NTHR-1:0]         ex_ready,
  output logic [NTHR-1:0]         mx_valid,
  output logic [NTHR*W-1:0]       mx_word,
  output logic [NTHR-1:0]         mx_from_boot,
  output logic [NTHR-1:0]         drop_flag
);

  logic        bt_in;
  logic [31:0] bt_win;

  assign bt_in  = bt_valid && in_windows(bt_addr, BASE, STRIDE, NTHR);
  assign bt_win = window_of(bt_addr, BASE, STRIDE);

  logic [NTHR-1:0] boot_hit, collide, rt_hang, fits;

  for (genvar t = 0; t < int'(NTHR); t++) begin : g_thr
    logic [CW-1:0]      rt_n, wr_n;
    logic [LANES*W-1:0] rt_words;
    logic [NW-1:0]      q_free;

    copro_push_route #(
      .W(W), .LANES(LANES), .NTHR(NTHR), .BASE(BASE), .STRIDE(STRIDE)
    ) u_route (
      .req_valid  (wk_valid[t]),
      .req_inline (wk_inline[t]),
      .req_count  (wk_count[t*CW +: CW]),
      .req_addr   (wk_addr[t*32 +: 32]),
      .req_data   (wk_data[t*LANES*W +: LANES*W]),
      .push_n     (rt_n),
      .push_words (rt_words),
      .hang       (rt_hang[t])
    );

    assign boot_hit[t] = bt_in && (bt_win == 32'(t));
    assign collide[t]  = boot_hit[t] && wk_valid[t] && !rt_hang[t] && (rt_n != '0);
    assign fits[t]     = NW'(rt_n) <= q_free;
    assign wk_ready[t] = wk_valid[t] && !rt_hang[t] && (collide[t] || fits[t]);
    assign wr_n        = (wk_ready[t] && !collide[t]) ? rt_n : '0;

    copro_push_queue #(.W(W), .DEPTH(DEPTH), .LANES(LANES)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_n     (wr_n),
      .wr_words (rt_words),
      .pop_req  (q_pop[t]),
      .valid    (q_valid[t]),
      .head     (q_word[t*W +: W]),
      .free     (q_free),
      .full     (q_full[t])
    );

    copro_push_merge #(.W(W)) u_merge (
      .boot_hit  (boot_hit[t]),
      .boot_word (bt_data),
      .ex_valid  (ex_valid[t]),
      .ex_word   (ex_word[t*W +: W]),
      .ex_ready  (ex_ready[t]),
      .mx_valid  (mx_valid[t]),
      .mx_word   (mx_word[t*W +: W]),
      .mx_boot   (mx_from_boot[t])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)          drop_flag[t] <= 1'b0;
      else if (collide[t]) drop_flag[t] <= 1'b1;
    end

    AST_HANG_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_valid[t] && rt_hang[t]) |-> !wk_ready[t]); // R2

    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(drop_flag[t]) |-> drop_flag[t]); // R8

    AST_COLLIDE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (collide[t] && !(q_pop[t] && q_valid[t])) |=> (q_free == $past(q_free))); // R8

    AST_BOOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      boot_hit[t] |-> (mx_valid[t] && mx_from_boot[t] && !ex_ready[t])); // R7

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full[t] && !collide[t] && rt_n != '0) |-> !wk_ready[t]); // R5
  end

endmodule

// File: tb/tb_copro_push_front.sv
module tb_copro_push_front;
  localparam int NT = 3, LN = 4, WD = 32, CWB = 3, DP = 32;
  localparam logic [31:0] BA = 32'hFFE4_0000, ST = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic [NT-1:0] wk_valid = '0, wk_inline = '0, wk_ready, q_valid, q_pop = '0, q_full;
  logic [NT*CWB-1:0] wk_count = '0;
  logic [NT*32-1:0] wk_addr = '0;
  logic [NT*LN*WD-1:0] wk_data = '0;
  logic bt_valid = 0;
  logic [31:0] bt_addr = '0, bt_data = '0;
  logic [NT*WD-1:0] q_word, ex_word = '0, mx_word;
  logic [NT-1:0] ex_valid = '0, ex_ready, mx_valid, mx_from_boot, drop_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  copro_push_front dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl2(input logic [31:0] x);
    return (x << 2) | (x >> 30);
  endfunction

  task automatic clear_req();
    wk_valid = '0; wk_inline = '0; bt_valid = 0; q_pop = '0; ex_valid = '0;
  endtask

  task automatic set_store(input int w, input logic [31:0] a, input logic [31:0] d);
    wk_valid[w] = 1; wk_inline[w] = 0; wk_addr[w*32 +: 32] = a; wk_data[w*LN*WD +: WD] = d;
  endtask

  task automatic pop_expect(input int t, input logic [31:0] exp, input string req);
    @(negedge clk);
    chk(q_valid[t] && q_word[t*WD +: WD] == exp, req, q_word[t*WD +: WD], exp);
    q_pop[t] = 1;
    @(negedge clk);
    q_pop[t] = 0;
  endtask

  task automatic drain(input int t);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      q_pop[t] = q_valid[t];
    end
    q_pop[t] = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(q_valid == 0 && q_full == 0, "R10 queues", {26'b0, q_full, q_valid}, 0);
    chk(drop_flag == 0 && mx_valid == 0, "R10 flags", {26'b0, mx_valid, drop_flag}, 0);
  endtask

  task automatic t_store_route();
    @(negedge clk); set_store(1, BA + 32'h40, 32'h28AB_CDEF);
    #1 chk(wk_ready[1], "R1 ready", wk_ready, 3'b010);
    @(negedge clk); clear_req();
    chk(q_valid == 3'b010, "R1 own queue only", q_valid, 3'b010);
    chk(q_word[WD +: WD] == 32'h28AB_CDEF, "R1 word", q_word[WD +: WD], 32'h28AB_CDEF);
    drain(1);
  endtask

  task automatic t_hang_and_outside();
    @(negedge clk); set_store(0, BA + ST, 32'h1111_0000);
    for (int i = 0; i < 4; i++) begin
      #1 chk(!wk_ready[0], "R2 window1 stalls", wk_ready, 0);
      @(negedge clk);
    end
    set_store(0, BA + 2*ST + 8, 32'h2222_0000);
    #1 chk(!wk_ready[0], "R2 window2 stalls", wk_ready, 0);
    @(negedge clk); set_store(0, 32'h0000_1000, 32'h3333_0000);
    #1 chk(wk_ready[0], "R2 outside accepted", wk_ready, 1);
    @(negedge clk); clear_req();
    chk(q_valid[0] == 0, "R2 nothing queued", q_valid, 0);
  endtask

  task automatic t_inline_rotate();
    @(negedge clk);
    wk_valid[0] = 1; wk_inline[0] = 1; wk_count[0 +: CWB] = 1; wk_addr[0 +: 32] = BA + 2*ST;
    wk_data[0 +: WD] = rotl2(32'hC000_0003);
    #1 chk(wk_ready[0], "R3 ready", wk_ready, 1);
    @(negedge clk); clear_req();
    chk(q_word[0 +: WD] == 32'hC000_0003, "R3 rotated back", q_word[0 +: WD], 32'hC000_0003);
    drain(0);
  endtask

  task automatic t_fused();
    @(negedge clk);
    wk_valid[2] = 1; wk_inline[2] = 1; wk_count[2*CWB +: CWB] = 4;
    for (int k = 0; k < LN; k++) wk_data[2*LN*WD + k*WD +: WD] = rotl2(32'h5800_0010 + k);
    #1 chk(wk_ready[2], "R4 fused ready", wk_ready, 3'b100);
    @(negedge clk); clear_req();
    for (int k = 0; k < LN; k++) pop_expect(2, 32'h5800_0010 + k, "R4 lane order");
    @(negedge clk);
    chk(!q_valid[2], "R6 empty after drain", q_valid, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DP; i++) begin
      @(negedge clk); set_store(1, BA, 32'hA000_0000 + i);
    end
    @(negedge clk); set_store(1, BA, 32'hBEEF_0000);
    chk(q_full[1], "R5 full at 32", q_full, 3'b010);
    #1 chk(!wk_ready[1], "R5 stall when full", wk_ready, 0);
    q_pop[1] = 1;
    #1 chk(!wk_ready[1], "R5 pop cycle still stalled", wk_ready, 0);
    @(negedge clk); q_pop[1] = 0;
    #1 chk(wk_ready[1], "R5 slot usable next cycle", wk_ready, 3'b010);
    @(negedge clk); clear_req();
    pop_expect(1, 32'hA000_0001, "R6 fifo order");
    drain(1);
  endtask

  task automatic t_fused_room();
    for (int i = 0; i < DP - 3; i++) begin
      @(negedge clk); set_store(2, BA, i);
    end
    @(negedge clk); clear_req();
    wk_valid[2] = 1; wk_inline[2] = 1; wk_count[2*CWB +: CWB] = 4;
    #1 chk(!wk_ready[2], "R4 group of 4 with 3 free stalls", wk_ready, 0);
    wk_count[2*CWB +: CWB] = 3;
    #1 chk(wk_ready[2], "R4 group of 3 fits", wk_ready, 3'b100);
    @(negedge clk); clear_req();
    chk(q_full[2], "R4 queue exactly full", q_full, 3'b100);
    drain(2);
  endtask

  task automatic t_boot_path();
    @(negedge clk);
    bt_valid = 1; bt_addr = BA + ST; bt_data = 32'h0A0B_0C0D;
    ex_valid = 3'b111; ex_word = {32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    #1 chk(mx_valid[1] && mx_from_boot[1] && !ex_ready[1], "R7 boot on thread1", {29'b0, mx_from_boot}, 3'b010);
    chk(mx_word[WD +: WD] == 32'h0A0B_0C0D, "R7 boot word", mx_word[WD +: WD], 32'h0A0B_0C0D);
    chk(mx_word[0 +: WD] == 32'h1111_1111 && ex_ready[0], "R9 thread0 forwards", mx_word[0 +: WD], 32'h1111_1111);
    bt_addr = BA + 2*ST;
    #1 chk(mx_from_boot == 3'b100, "R7 boot on thread2", mx_from_boot, 3'b100);
    @(negedge clk); clear_req();
    chk(q_valid == 0, "R7 queue untouched", q_valid, 0);
    #1 chk(mx_valid == 0 && ex_ready == 3'b111, "R9 idle merge", {29'b0, ex_ready}, 3'b111);
  endtask

  task automatic t_collision();
    @(negedge clk);
    bt_valid = 1; bt_addr = BA; bt_data = 32'hB007_0001;
    set_store(0, BA, 32'hDEAD_0001);
    #1 chk(wk_ready[0], "R8 worker still sees ready", wk_ready, 1);
    chk(mx_word[0 +: WD] == 32'hB007_0001, "R8 boot word wins", mx_word[0 +: WD], 32'hB007_0001);
    @(negedge clk); clear_req();
    chk(!q_valid[0], "R8 worker word lost", q_valid, 0);
    chk(drop_flag == 3'b001, "R8 drop flag set", drop_flag, 3'b001);
    repeat (3) @(negedge clk);
    chk(drop_flag == 3'b001, "R8 drop flag sticky", drop_flag, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_store_route();
    t_hang_and_outside();
    t_inline_rotate();
    t_fused();
    t_full();
    t_fused_room();
    t_boot_path();
    t_collision();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule